// File: doc/BRIEF.md
# MESI Line State Controller

This block holds the coherence state of every line in a small data cache and moves each state as local reads and writes arrive and as other agents' bus traffic is snooped. The tags sit in a fully associative array of `LINES` entries. Each entry keeps a tag and a two-bit state: Invalid, Shared, Exclusive or Modified. Line data is not stored here. The block decides only when a line must be fetched, invalidated elsewhere or written back, and it issues those actions as requests on a bus port.

Each local request is a read or a write of one tag. A hit answers on the next cycle. A miss picks a victim slot with a round-robin pointer. If the victim is dirty, its write-back goes out first. The fill comes next, and its result depends on whether another agent reports a shared copy. A write to a Shared line first broadcasts an invalidate. Snoops are taken only while the controller is idle, and they take priority over a local request in the same cycle. A snoop that hits a Modified line reports it as dirty and forces a write-back. If the snoop was a write, the controller also tells the requester to cancel its transaction.

The parameter `INSTR_SIDE` builds the instruction-side variant. Its lines only ever hold Shared or Invalid, and it ignores write requests.

The controller states are `CS_IDLE`, `CS_EVICT_WB`, `CS_FILL_REQ`, `CS_FILL_WAIT`, `CS_INV_REQ` and `CS_SNP_WB`. Their transitions are:
- `CS_IDLE` moves to `CS_SNP_WB` on a snoop hit to a Modified line. On a local miss it moves to `CS_EVICT_WB` if the victim is dirty, and to `CS_FILL_REQ` if not. On a write hit to a Shared line it moves to `CS_INV_REQ`.
- `CS_EVICT_WB` moves to `CS_FILL_REQ` on bus ready.
- `CS_FILL_REQ` moves to `CS_FILL_WAIT` on bus ready.
- `CS_FILL_WAIT` moves on bus done. It goes to `CS_INV_REQ` for a write miss filled shared, and to `CS_IDLE` otherwise.
- `CS_INV_REQ` and `CS_SNP_WB` return to `CS_IDLE` on bus ready.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and the controller is idle. `req_ready` and `snp_ready` are 1, `bus_valid` is 0, and a snoop of any tag reports `snp_hit` = 0.
- R2: A read miss issues one bus request with `bus_op` = 1 (fill) carrying the requested tag, then answers with `rsp_hit` = 0. The line becomes Exclusive if `bus_shared` = 0 when `bus_done` arrives, and Shared if it is 1.
- R3: A read hit answers one cycle after acceptance with `rsp_valid` = 1 and `rsp_hit` = 1. It issues no bus request.
- R4: A write hit to an Exclusive or Modified line answers on the next cycle with `rsp_hit` = 1 and no bus request, and it leaves the line Modified.
- R5: A write hit to a Shared line issues `bus_op` = 2 (invalidate) with the line's tag. It answers with `rsp_hit` = 1 only after that request is accepted, and the line becomes Modified.
- R6: A write miss issues a fill. If the fill returns not shared, the line becomes Modified. If it returns shared, an invalidate with the same tag follows the fill, and the line then becomes Modified. Either way the answer carries `rsp_hit` = 0.
- R7: A snoop read (`snp_write` = 0) that hits a Modified line reports `snp_hitm` = 1 and issues `bus_op` = 3 (write-back) with that tag. The line becomes Shared. A snoop read that hits an Exclusive line moves it to Shared with no bus request.
- R8: A snoop write or invalidate (`snp_write` = 1) invalidates any line it hits. If the line was Modified, `snp_cancel` and `snp_hitm` are 1 and a write-back is issued. If it was Shared or Exclusive, `snp_hitm` and `snp_cancel` are 0 and no bus request is made.
- R9: Victim slots are chosen in round-robin order 0, 1, 2, … from reset. A Modified victim's write-back, which carries the old tag, is issued before the fill of the new tag.
- R10: While `bus_valid` = 1 and `bus_ready` = 0, `bus_valid`, `bus_op` and `bus_tag` hold. At most one bus request is outstanding at a time.
- R11: With `INSTR_SIDE` = 1, every fill leaves the line Shared and no line is ever Exclusive or Modified. A write request answers at once with `rsp_hit` = 0 and changes nothing. Snoops never report `snp_hitm`.
- R12: A snoop takes priority over a local request: `req_ready` is 0 in any cycle in which `snp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Tag of the local request |
| req_ready | output | 1 | Local request accepted this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Request hit a valid line |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_write | input | 1 | 1 = write or invalidate, 0 = read |
| snp_tag | input | TAG_W | Tag of the snooped transaction |
| snp_ready | output | 1 | Snoop accepted this cycle |
| snp_ack | output | 1 | One-cycle snoop result pulse |
| snp_hit | output | 1 | Snoop hit a valid line |
| snp_hitm | output | 1 | Snoop hit a Modified line |
| snp_cancel | output | 1 | Requester must cancel its write |
| bus_valid | output | 1 | Bus request present |
| bus_op | output | 2 | 1 fill, 2 invalidate, 3 write-back |
| bus_tag | output | TAG_W | Tag of the bus request |
| bus_ready | input | 1 | Bus request accepted |
| bus_done | input | 1 | Fill data returned |
| bus_shared | input | 1 | Another agent holds the filled line |

## Verification
The bench walks a single line through every state: Exclusive to Modified silently, Modified to Shared on a snoop read, Shared to Modified through an invalidate, and Modified to Invalid on a snoop write. A design that broadcast an invalidate for an Exclusive write, or skipped it for a Shared one, shows up in the logged bus operations. A controller that left a line dirty after a snoop read would answer the next snoop read with hitm. The eviction test fills all four slots so that the round-robin victim is a Modified line. It then checks that the write-back carries the old tag and comes before the fill, which exposes a wrong pointer or a write-back-after-fill ordering. The write-miss-shared case catches a design that treats a shared fill as ownership. A second instance built as the instruction-side variant checks that writes leave a line readable and that no snoop ever sees it dirty. The bench also holds `bus_ready` low to expose a request that changes before it is taken.

// File: rtl/coh_pkg.sv
package coh_pkg;

    // Coherence state of one line; the two-bit code is stored per line.
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    // Operation code driven on the bus request port.
    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_FILL = 2'd1,
        BOP_INV  = 2'd2,
        BOP_WB   = 2'd3
    } bus_op_t;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_EVICT_WB,
        CS_FILL_REQ,
        CS_FILL_WAIT,
        CS_INV_REQ,
        CS_SNP_WB
    } ctl_st_t;

endpackage

// File: rtl/coh_tag_match.sv
module coh_tag_match #(
    parameter int LINES = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LINES-1:0][TAG_W-1:0]   tags,
    input  logic [LINES-1:0]              valid,
    input  logic [TAG_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    // R9: a tag never lives in two valid slots at once
    dup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/coh_rr_ptr.sv
module coh_rr_ptr #(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R9: pointer stays inside the array
    rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int LINES      = 4,
    parameter int TAG_W      = 8,
    parameter bit INSTR_SIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_hit,
    input  logic             snp_valid,
    input  logic             snp_write,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_ready,
    output logic             snp_ack,
    output logic             snp_hit,
    output logic             snp_hitm,
    output logic             snp_cancel,
    output logic             bus_valid,
    output logic [1:0]       bus_op,
    output logic [TAG_W-1:0] bus_tag,
    input  logic             bus_ready,
    input  logic             bus_done,
    input  logic             bus_shared
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    line_st_t                   lst [LINES];
    logic [LINES-1:0][TAG_W-1:0] ltag;
    logic [LINES-1:0]           lvalid;

    ctl_st_t          st, st_nx;
    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;
    logic             cur_write, cur_hit;

    logic             r_hit, s_hit;
    logic [IDX_W-1:0] r_idx, s_idx, victim;
    line_st_t         r_st, s_st, v_st, fill_st;
    logic             snp_go, req_go, miss_go, wr_drop;
    bus_op_t          bop;

    for (genvar g = 0; g < LINES; g++) begin : g_valid
        assign lvalid[g] = (lst[g] != LS_I);
    end

    coh_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_req_match (
        .clk(clk), .rst_n(rst_n), .tags(ltag), .valid(lvalid),
        .key(req_tag), .hit(r_hit), .idx(r_idx));

    coh_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_snp_match (
        .clk(clk), .rst_n(rst_n), .tags(ltag), .valid(lvalid),
        .key(snp_tag), .hit(s_hit), .idx(s_idx));

    coh_rr_ptr #(.LINES(LINES)) u_rr (
        .clk(clk), .rst_n(rst_n), .adv(miss_go), .ptr(victim));

    assign r_st      = lst[r_idx];
    assign s_st      = lst[s_idx];
    assign v_st      = lst[victim];
    assign snp_ready = (st == CS_IDLE);
    assign req_ready = (st == CS_IDLE) && !snp_valid;
    assign snp_go    = snp_valid && snp_ready;
    assign req_go    = req_valid && req_ready;
    assign wr_drop   = INSTR_SIDE && req_write;
    assign miss_go   = req_go && !r_hit && !wr_drop;

    // Fill result: the instruction-side variant never takes ownership.
    if (INSTR_SIDE) begin : g_isd_fill
        assign fill_st = LS_S;
    end else begin : g_dsd_fill
        assign fill_st = bus_shared ? LS_S : LS_E;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CS_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            CS_IDLE: begin
                if (snp_go) begin
                    if (s_hit && s_st == LS_M) st_nx = CS_SNP_WB;
                end else if (req_go && !wr_drop) begin
                    if (r_hit) begin
                        if (req_write && r_st == LS_S) st_nx = CS_INV_REQ;
                    end else begin
                        st_nx = (v_st == LS_M) ? CS_EVICT_WB : CS_FILL_REQ;
                    end
                end
            end
            CS_EVICT_WB:  if (bus_ready) st_nx = CS_FILL_REQ;
            CS_FILL_REQ:  if (bus_ready) st_nx = CS_FILL_WAIT;
            CS_FILL_WAIT: if (bus_done)
                              st_nx = (cur_write && !INSTR_SIDE && bus_shared) ? CS_INV_REQ : CS_IDLE;
            CS_INV_REQ:   if (bus_ready) st_nx = CS_IDLE;
            CS_SNP_WB:    if (bus_ready) st_nx = CS_IDLE;
            default:      st_nx = CS_IDLE;
        endcase
    end

    // Bus request outputs
    always_comb begin
        bop     = BOP_NONE;
        bus_tag = cur_tag;
        unique case (st)
            CS_EVICT_WB: begin bop = BOP_WB; bus_tag = ltag[cur_idx]; end
            CS_FILL_REQ: bop = BOP_FILL;
            CS_INV_REQ:  bop = BOP_INV;
            CS_SNP_WB:   bop = BOP_WB;
            default:     bop = BOP_NONE;
        endcase
    end
    assign bus_valid = (bop != BOP_NONE);
    assign bus_op    = bop;

    // Line array, request context and responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) lst[i] <= LS_I;
            ltag       <= '0;
            cur_idx    <= '0;
            cur_tag    <= '0;
            cur_write  <= 1'b0;
            cur_hit    <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            snp_ack    <= 1'b0;
            snp_hit    <= 1'b0;
            snp_hitm   <= 1'b0;
            snp_cancel <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            snp_ack    <= 1'b0;
            snp_hit    <= 1'b0;
            snp_hitm   <= 1'b0;
            snp_cancel <= 1'b0;
            case (st)
                CS_IDLE: begin
                    if (snp_go) begin
                        snp_ack    <= 1'b1;
                        snp_hit    <= s_hit;
                        snp_hitm   <= s_hit && (s_st == LS_M);
                        snp_cancel <= s_hit && (s_st == LS_M) && snp_write;
                        cur_tag    <= snp_tag;
                        if (s_hit) lst[s_idx] <= snp_write ? LS_I : LS_S;
                    end else if (req_go) begin
                        cur_tag   <= req_tag;
                        cur_write <= req_write;
                        if (wr_drop) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                        end else if (r_hit) begin
                            cur_idx <= r_idx;
                            cur_hit <= 1'b1;
                            if (!req_write) begin
                                rsp_valid <= 1'b1;
                                rsp_hit   <= 1'b1;
                            end else if (r_st != LS_S) begin
                                lst[r_idx] <= LS_M;
                                rsp_valid  <= 1'b1;
                                rsp_hit    <= 1'b1;
                            end
                        end else begin
                            cur_idx     <= victim;
                            cur_hit     <= 1'b0;
                            lst[victim] <= LS_I;
                        end
                    end
                end
                CS_FILL_WAIT: begin
                    if (bus_done) begin
                        ltag[cur_idx] <= cur_tag;
                        if (cur_write && !INSTR_SIDE) begin
                            if (bus_shared) begin
                                lst[cur_idx] <= LS_S;
                            end else begin
                                lst[cur_idx] <= LS_M;
                                rsp_valid    <= 1'b1;
                                rsp_hit      <= 1'b0;
                            end
                        end else begin
                            lst[cur_idx] <= fill_st;
                            rsp_valid    <= 1'b1;
                            rsp_hit      <= 1'b0;
                        end
                    end
                end
                CS_INV_REQ: begin
                    if (bus_ready) begin
                        lst[cur_idx] <= LS_M;
                        rsp_valid    <= 1'b1;
                        rsp_hit      <= cur_hit;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_op) && $stable(bus_tag));

    // R8
    cancel_hitm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_cancel |-> snp_hitm && snp_ack);

    // R7
    snp_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> bus_valid && bus_op == 2'd3);

    // R3
    rd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_go && !req_write && r_hit |=> rsp_valid && rsp_hit);

    // R12
    snp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !req_ready);

    if (INSTR_SIDE) begin : g_isd_chk
        for (genvar g = 0; g < LINES; g++) begin : g_line
            // R11
            isd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lst[g] == LS_S || lst[g] == LS_I);
        end
    end

endmodule

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;

    localparam int TAG_W = 8;
    localparam int LINES = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n = 1'b0;

    logic             req_valid [2];
    logic             req_write [2];
    logic [TAG_W-1:0] req_tag   [2];
    logic             snp_valid [2];
    logic             snp_write [2];
    logic [TAG_W-1:0] snp_tag   [2];
    logic             bus_ready [2];
    logic             bus_done  [2];
    logic             bus_shared[2];
    logic             req_ready [2];
    logic             rsp_valid [2];
    logic             rsp_hit   [2];
    logic             snp_ready [2];
    logic             snp_ack   [2];
    logic             snp_hit   [2];
    logic             snp_hitm  [2];
    logic             snp_cancel[2];
    logic             bus_valid [2];
    logic [1:0]       bus_op    [2];
    logic [TAG_W-1:0] bus_tag   [2];

    coh_line_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .INSTR_SIDE(1'b0)) u_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[0]), .req_write(req_write[0]), .req_tag(req_tag[0]),
        .req_ready(req_ready[0]), .rsp_valid(rsp_valid[0]), .rsp_hit(rsp_hit[0]),
        .snp_valid(snp_valid[0]), .snp_write(snp_write[0]), .snp_tag(snp_tag[0]),
        .snp_ready(snp_ready[0]), .snp_ack(snp_ack[0]), .snp_hit(snp_hit[0]),
        .snp_hitm(snp_hitm[0]), .snp_cancel(snp_cancel[0]),
        .bus_valid(bus_valid[0]), .bus_op(bus_op[0]), .bus_tag(bus_tag[0]),
        .bus_ready(bus_ready[0]), .bus_done(bus_done[0]), .bus_shared(bus_shared[0]));

    coh_line_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .INSTR_SIDE(1'b1)) u_coh_line_ctrl_isd (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[1]), .req_write(req_write[1]), .req_tag(req_tag[1]),
        .req_ready(req_ready[1]), .rsp_valid(rsp_valid[1]), .rsp_hit(rsp_hit[1]),
        .snp_valid(snp_valid[1]), .snp_write(snp_write[1]), .snp_tag(snp_tag[1]),
        .snp_ready(snp_ready[1]), .snp_ack(snp_ack[1]), .snp_hit(snp_hit[1]),
        .snp_hitm(snp_hitm[1]), .snp_cancel(snp_cancel[1]),
        .bus_valid(bus_valid[1]), .bus_op(bus_op[1]), .bus_tag(bus_tag[1]),
        .bus_ready(bus_ready[1]), .bus_done(bus_done[1]), .bus_shared(bus_shared[1]));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int ops  [8];
    int tags [8];
    int nops;
    int got_rsp, got_hit;
    int s_ack, s_hit, s_hitm, s_cancel;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Local request plus a bus responder; rdly holds bus_ready off per request.
    task automatic run_req(input int s, input bit wr, input logic [TAG_W-1:0] tag,
                           input bit shared, input int rdly);
        bit fill_pend = 1'b0;
        int waitc = 0;
        int held = 0;
        nops = 0; got_rsp = 0; got_hit = 0;
        @(negedge clk);
        req_valid[s] = 1'b1; req_write[s] = wr; req_tag[s] = tag; bus_shared[s] = shared;
        @(posedge clk);
        @(negedge clk);
        req_valid[s] = 1'b0;
        for (int k = 0; k < 40; k++) begin
            bus_ready[s] = 1'b0; bus_done[s] = 1'b0;
            if (rsp_valid[s]) begin
                got_rsp = 1; got_hit = int'(rsp_hit[s]);
                break;
            end
            if (bus_valid[s]) begin
                if (waitc < rdly) begin
                    if (waitc == 0) held = int'(bus_op[s]);
                    else chk("R10", "op held while not ready", int'(bus_op[s]), held);
                    waitc++;
                end else begin
                    if (nops < 8) begin
                        ops[nops] = int'(bus_op[s]); tags[nops] = int'(bus_tag[s]);
                    end
                    nops++;
                    bus_ready[s] = 1'b1;
                    waitc = 0;
                    if (bus_op[s] == 2'd1) fill_pend = 1'b1;
                end
            end else if (fill_pend) begin
                bus_done[s] = 1'b1;
                fill_pend = 1'b0;
            end
            @(negedge clk);
        end
        bus_ready[s] = 1'b0; bus_done[s] = 1'b0;
    endtask

    task automatic run_snp(input int s, input bit wr, input logic [TAG_W-1:0] tag);
        nops = 0;
        @(negedge clk);
        snp_valid[s] = 1'b1; snp_write[s] = wr; snp_tag[s] = tag;
        @(posedge clk);
        @(negedge clk);
        snp_valid[s] = 1'b0;
        s_ack = int'(snp_ack[s]); s_hit = int'(snp_hit[s]);
        s_hitm = int'(snp_hitm[s]); s_cancel = int'(snp_cancel[s]);
        for (int k = 0; k < 4; k++) begin
            bus_ready[s] = 1'b0;
            if (bus_valid[s]) begin
                if (nops < 8) begin
                    ops[nops] = int'(bus_op[s]); tags[nops] = int'(bus_tag[s]);
                end
                nops++;
                bus_ready[s] = 1'b1;
            end
            @(negedge clk);
        end
        bus_ready[s] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "req_ready", int'(req_ready[0]), 1);
        chk("R1", "snp_ready", int'(snp_ready[0]), 1);
        chk("R1", "bus_valid", int'(bus_valid[0]), 0);
        chk("R1", "rsp_valid", int'(rsp_valid[0]), 0);
        run_snp(0, 1'b0, 8'h00);
        chk("R1", "snoop ack", s_ack, 1);
        chk("R1", "snoop hit after reset", s_hit, 0);
    endtask

    task automatic t_fill_excl();
        run_req(0, 1'b0, 8'h11, 1'b0, 2);
        chk("R2", "response", got_rsp, 1);
        chk("R2", "hit", got_hit, 0);
        chk("R2", "bus op count", nops, 1);
        chk("R2", "fill op", ops[0], 1);
        chk("R2", "fill tag", tags[0], 'h11);
    endtask

    task automatic t_read_hit();
        run_req(0, 1'b0, 8'h11, 1'b0, 0);
        chk("R3", "hit", got_hit, 1);
        chk("R3", "no bus op", nops, 0);
    endtask

    task automatic t_write_excl();
        run_req(0, 1'b1, 8'h11, 1'b0, 0);
        chk("R4", "E write hit", got_hit, 1);
        chk("R4", "E write silent", nops, 0);
        run_req(0, 1'b1, 8'h11, 1'b0, 0);
        chk("R4", "M write hit", got_hit, 1);
        chk("R4", "M write silent", nops, 0);
    endtask

    task automatic t_snp_rd_m();
        run_snp(0, 1'b0, 8'h11);
        chk("R7", "hit", s_hit, 1);
        chk("R7", "hitm", s_hitm, 1);
        chk("R7", "no cancel on read", s_cancel, 0);
        chk("R7", "wb count", nops, 1);
        chk("R7", "wb op", ops[0], 3);
        chk("R7", "wb tag", tags[0], 'h11);
        run_snp(0, 1'b0, 8'h11);
        chk("R7", "second snoop hit (S)", s_hit, 1);
        chk("R7", "second snoop not dirty", s_hitm, 0);
        chk("R7", "second snoop no bus op", nops, 0);
    endtask

    task automatic t_write_shared();
        run_req(0, 1'b1, 8'h11, 1'b0, 0);
        chk("R5", "hit", got_hit, 1);
        chk("R5", "inv count", nops, 1);
        chk("R5", "inv op", ops[0], 2);
        chk("R5", "inv tag", tags[0], 'h11);
    endtask

    task automatic t_snp_wr_m();
        run_snp(0, 1'b1, 8'h11);
        chk("R8", "hitm (line was M after R5)", s_hitm, 1);
        chk("R8", "cancel", s_cancel, 1);
        chk("R8", "wb count", nops, 1);
        chk("R8", "wb op", ops[0], 3);
        run_req(0, 1'b0, 8'h11, 1'b1, 0);
        chk("R8", "line invalid: read misses", got_hit, 0);
        chk("R2", "shared fill op", ops[0], 1);
    endtask

    task automatic t_snp_wr_s();
        run_snp(0, 1'b1, 8'h11);
        chk("R8", "S snoop write hit", s_hit, 1);
        chk("R8", "S snoop write hitm", s_hitm, 0);
        chk("R8", "S snoop write cancel", s_cancel, 0);
        chk("R8", "S snoop write no bus", nops, 0);
        run_snp(0, 1'b0, 8'h11);
        chk("R8", "line now invalid", s_hit, 0);
    endtask

    task automatic t_write_miss();
        run_req(0, 1'b1, 8'h22, 1'b0, 0);
        chk("R6", "miss", got_hit, 0);
        chk("R6", "fill only", nops, 1);
        chk("R6", "fill tag", tags[0], 'h22);
        run_snp(0, 1'b0, 8'h22);
        chk("R6", "line M after exclusive fill", s_hitm, 1);
        run_req(0, 1'b1, 8'h33, 1'b1, 0);
        chk("R6", "shared miss", got_hit, 0);
        chk("R6", "fill then inv", nops, 2);
        chk("R6", "first op fill", ops[0], 1);
        chk("R6", "second op inv", ops[1], 2);
        chk("R6", "inv tag", tags[1], 'h33);
    endtask

    task automatic t_evict();
        run_req(0, 1'b0, 8'h44, 1'b0, 0);
        chk("R9", "slot0 fill", nops, 1);
        run_req(0, 1'b0, 8'h55, 1'b0, 0);
        chk("R9", "slot1 fill", nops, 1);
        run_req(0, 1'b0, 8'h66, 1'b0, 0);
        chk("R9", "slot2 clean victim", nops, 1);
        run_req(0, 1'b0, 8'h77, 1'b0, 0);
        chk("R9", "slot3 dirty victim ops", nops, 2);
        chk("R9", "wb first", ops[0], 3);
        chk("R9", "wb old tag", tags[0], 'h33);
        chk("R9", "fill second", ops[1], 1);
        chk("R9", "fill new tag", tags[1], 'h77);
        run_snp(0, 1'b0, 8'h22);
        chk("R9", "evicted 22 gone", s_hit, 0);
        run_req(0, 1'b0, 8'h44, 1'b0, 0);
        chk("R9", "slot0 kept", got_hit, 1);
    endtask

    task automatic t_prio();
        @(negedge clk);
        snp_valid[0] = 1'b1; snp_write[0] = 1'b0; snp_tag[0] = 8'h55;
        req_valid[0] = 1'b1; req_write[0] = 1'b0; req_tag[0] = 8'h44;
        #1;
        chk("R12", "req_ready low under snoop", int'(req_ready[0]), 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid[0] = 1'b0; req_valid[0] = 1'b0;
        chk("R12", "snoop served", int'(snp_ack[0]), 1);
        chk("R12", "request not served", int'(rsp_valid[0]), 0);
    endtask

    task automatic t_isd();
        run_req(1, 1'b0, 8'h5A, 1'b0, 0);
        chk("R11", "fill", nops, 1);
        chk("R11", "miss", got_hit, 0);
        run_snp(1, 1'b0, 8'h5A);
        chk("R11", "snoop hit", s_hit, 1);
        chk("R11", "never dirty", s_hitm, 0);
        chk("R11", "no wb", nops, 0);
        run_req(1, 1'b1, 8'h5A, 1'b0, 0);
        chk("R11", "write answered", got_rsp, 1);
        chk("R11", "write hit flag", got_hit, 0);
        chk("R11", "write no bus", nops, 0);
        run_req(1, 1'b0, 8'h5A, 1'b0, 0);
        chk("R11", "still readable", got_hit, 1);
        run_snp(1, 1'b1, 8'h5A);
        chk("R11", "snoop write no cancel", s_cancel, 0);
        run_req(1, 1'b0, 8'h5A, 1'b0, 0);
        chk("R11", "invalidated", got_hit, 0);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            req_valid[i] = 0; req_write[i] = 0; req_tag[i] = '0;
            snp_valid[i] = 0; snp_write[i] = 0; snp_tag[i] = '0;
            bus_ready[i] = 0; bus_done[i] = 0; bus_shared[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_excl();
        t_read_hit();
        t_write_excl();
        t_snp_rd_m();
        t_write_shared();
        t_snp_wr_m();
        t_snp_wr_s();
        t_write_miss();
        t_evict();
        t_prio();
        t_isd();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule